// File: doc/BRIEF.md
# Programmable Radix-4 Threshold Literal Network

This cell turns one four-valued digit (0 to 3) into a single binary decision. Inside it are four switches. Each switch holds a small stored value, its threshold. A switch conducts when the incoming digit is strictly larger than that threshold. The four switches form two chains of two. Each chain conducts only when both of its switches conduct, which gives an AND. The output is high when either chain conducts, which gives an OR. Each switch can also flip the digit to 3 minus the digit before it compares. With that option, any of the sixteen functions of one four-valued digit can be built from the cell.

Thresholds are loaded one switch at a time through a synchronous write port. The decision itself has no register. It follows the digit and the stored configuration within the same cycle. After reset, every threshold sits at its lowest value, so every switch conducts and the output is high.

Top module: `tlit_network`

## Requirements
- R1: After reset every switch has threshold -1 and remap off, so `match_o` is 1 for every digit value.
- R2: A switch with remap off conducts exactly when the digit, read as unsigned 0..3, is strictly greater than its threshold, read as 3-bit two's complement (`wr_data_i[2:0]`).
- R3: A threshold of 3 makes its switch never conduct, and a threshold of -1 (code 3'b111) makes it always conduct.
- R4: `match_o` = (S0 AND S1) OR (S2 AND S3), where Sk is the switch selected by `wr_addr_i` = k.
- R5: A write with `wr_en_i` high takes effect at the next rising clock edge. Before that edge the output still reflects the old threshold. The output responds to a change of `digit_i` with no clock.
- R6: When a switch's remap bit (`wr_data_i[3]`) is 1, that switch compares 3 minus the digit, instead of the digit, against its threshold.
- R7: While `wr_en_i` is low, the values on `wr_addr_i` and `wr_data_i` change no stored configuration.
- R8: The negative threshold codes -4, -3 and -2 behave like -1: the switch always conducts.
- R9: Every one of the sixteen binary functions of the digit can be loaded into the cell. Each run of accepted digits [a,b] maps to one chain, with one switch set to threshold a-1 and remap off, and the other set to threshold 2-b and remap on. An unused chain holds threshold 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_i | input | 2 | External four-valued digit, 0..3 |
| wr_en_i | input | 1 | Write strobe for one switch configuration |
| wr_addr_i | input | 2 | Index of the switch being written |
| wr_data_i | input | 4 | Bit 3: remap enable; bits 2:0: signed threshold |
| match_o | output | 1 | Binary result of the network |

## Verification
The output is due in the same cycle as a digit change. The bench drives `digit_i` on the falling edge and samples `match_o` one nanosecond later. A write is due after exactly one rising edge. Each write is therefore checked twice: once just before that edge, where the old function must still hold, and once after it across all four digit values. Ignored writes are checked the same way, by sweeping the digit after the edge at which a write would have landed.

// File: rtl/tlit_pkg.sv
package tlit_pkg;
    localparam int DIGIT_W = 2;
    localparam int THR_W   = 3;

    // One switch setting: remap flag above a signed threshold.
    typedef struct packed {
        logic                    remap;
        logic signed [THR_W-1:0] thr;
    } lit_cfg_t;

    localparam int CFG_W = $bits(lit_cfg_t);
    localparam lit_cfg_t CFG_RESET = '{remap: 1'b0, thr: -3'sd1};
endpackage

// File: rtl/tlit_cfg_bank.sv
module tlit_cfg_bank
    import tlit_pkg::*;
#(
    parameter int NUM_LIT = 4,
    localparam int AW = (NUM_LIT > 1) ? $clog2(NUM_LIT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [AW-1:0]              wr_addr_i,
    input  logic [CFG_W-1:0]           wr_data_i,
    output lit_cfg_t [NUM_LIT-1:0]     cfg_o
);
    lit_cfg_t [NUM_LIT-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LIT; k++) cfg_q[k] <= CFG_RESET;
        end else if (wr_en_i) begin
            cfg_q[wr_addr_i] <= lit_cfg_t'(wr_data_i);
        end
    end

    assign cfg_o = cfg_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cfg_q[$past(wr_addr_i)] == lit_cfg_t'($past(wr_data_i))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/tlit_eval.sv
module tlit_eval
    import tlit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_i,
    input  lit_cfg_t           cfg_i,
    output logic               lit_o
);
    logic [DIGIT_W-1:0]      eff_digit;
    logic signed [THR_W-1:0] digit_s;

    // Converter: 0,1,2,3 -> 3,2,1,0 when remap is set.
    always_comb begin
        eff_digit = cfg_i.remap ? ~digit_i : digit_i;
        digit_s   = $signed({1'b0, eff_digit});
        lit_o     = (digit_s > cfg_i.thr);
    end

    AST_CEIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.thr == 3'sd3) |-> !lit_o); // R3
    AST_FLOOR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.thr[THR_W-1] |-> lit_o); // R8
endmodule

// File: rtl/tlit_network.sv
module tlit_network
    import tlit_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    localparam int NUM_LIT  = 2 * NUM_PAIRS,
    localparam int AW       = (NUM_LIT > 1) ? $clog2(NUM_LIT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [CFG_W-1:0]   wr_data_i,
    output logic               match_o
);
    lit_cfg_t [NUM_LIT-1:0] cfg;
    logic [NUM_LIT-1:0]     lit;
    logic [NUM_PAIRS-1:0]   chain_on;

    tlit_cfg_bank #(.NUM_LIT(NUM_LIT)) cfg_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    for (genvar k = 0; k < NUM_LIT; k++) begin : g_lit
        tlit_eval eval_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .digit_i (digit_i),
            .cfg_i   (cfg[k]),
            .lit_o   (lit[k])
        );
    end

    // Series pairs, then parallel paths.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chain
        assign chain_on[p] = lit[2*p] & lit[2*p+1];
    end

    assign match_o = |chain_on;

    AST_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (lit == {NUM_LIT{1'b1}}) |-> match_o); // R4
    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lit == '0) |-> !match_o); // R4
endmodule

// File: tb/tlit_network_tb.sv
module tlit_network_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] digit_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [3:0] wr_data_i = '0;
    logic       match_o;

    int checks = 0;
    int errors = 0;
    int m_thr [4];
    bit m_rm  [4];

    always #4 clk = ~clk;

    tlit_network dut_i (
        .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .match_o(match_o)
    );

    function automatic bit model(int x);
        bit l [4];
        for (int k = 0; k < 4; k++) l[k] = ((m_rm[k] ? 3 - x : x) > m_thr[k]);
        return (l[0] && l[1]) || (l[2] && l[3]);
    endfunction

    task automatic check(bit got, bit exp, string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: match_o=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic sweep(string req);
        for (int x = 0; x < 4; x++) begin
            @(negedge clk);
            digit_i = 2'(x);
            #1 check(match_o, model(x), req);
        end
    endtask

    // Write one switch; verify the old function until the edge (R5).
    task automatic put(int addr, bit rm, int thr);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 2'(addr); wr_data_i = {rm, 3'(thr)};
        #1 check(match_o, model(int'(digit_i)), "R5 pre-edge");
        @(posedge clk);
        m_thr[addr] = thr; m_rm[addr] = rm;
        #1 wr_en_i = 1'b0;
        check(match_o, model(int'(digit_i)), "R5 post-edge");
    endtask

    task automatic t_reset;
        for (int k = 0; k < 4; k++) begin m_thr[k] = -1; m_rm[k] = 0; end
        for (int x = 0; x < 4; x++) begin
            @(negedge clk); digit_i = 2'(x);
            #1 check(match_o, 1'b1, "R1");
        end
    endtask

    task automatic t_strict;
        put(2, 0, 3); put(3, 0, 3); put(1, 0, -1);
        for (int k = -1; k <= 3; k++) begin
            put(0, 0, k);
            for (int x = 0; x < 4; x++) begin
                @(negedge clk); digit_i = 2'(x);
                #1 check(match_o, x > k, (k == 3 || k == -1) ? "R3" : "R2");
            end
        end
    endtask

    task automatic t_remap;
        put(0, 1, 1);
        for (int x = 0; x < 4; x++) begin
            @(negedge clk); digit_i = 2'(x);
            #1 check(match_o, x < 2, "R6");
        end
    endtask

    task automatic t_compose;
        put(0, 0, 0); put(1, 0, 1); put(2, 0, 2); put(3, 0, -1);
        sweep("R4 pair0 x>1 or pair1 x>2");
        put(1, 1, 1); put(2, 0, 2); put(3, 1, 3);
        sweep("R4 pair1 blocked");
    endtask

    task automatic t_ignore;
        put(0, 0, 1); put(1, 0, -1); put(2, 0, 3); put(3, 0, 3);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            wr_en_i = 1'b0; wr_addr_i = 2'(a); wr_data_i = 4'b1011;
            @(posedge clk);
            sweep("R7");
        end
    endtask

    task automatic t_negcodes;
        put(1, 0, -1); put(2, 0, 3); put(3, 0, 3);
        for (int c = -4; c <= -2; c++) begin
            put(0, 0, c);
            for (int x = 0; x < 4; x++) begin
                @(negedge clk); digit_i = 2'(x);
                #1 check(match_o, 1'b1, "R8");
            end
        end
    endtask

    task automatic t_universal;
        for (int f = 0; f < 16; f++) begin
            int a [2]; int b [2]; int n; int s;
            n = 0; s = -1;
            for (int x = 0; x <= 4; x++) begin
                bit inside_f;
                inside_f = (x < 4) && f[x];
                if (inside_f && s < 0) s = x;
                if (!inside_f && s >= 0) begin a[n] = s; b[n] = x - 1; n++; s = -1; end
            end
            for (int p = 0; p < 2; p++) begin
                if (p < n) begin put(2*p, 0, a[p] - 1); put(2*p+1, 1, 2 - b[p]); end
                else begin put(2*p, 0, 3); put(2*p+1, 0, 3); end
            end
            for (int x = 0; x < 4; x++) begin
                @(negedge clk); digit_i = 2'(x);
                #1 check(match_o, f[x], "R9");
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_strict();
        t_remap();
        t_compose();
        t_ignore();
        t_negcodes();
        t_universal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule